// File: doc/BRIEF.md
# Dual-Rail Completion-Detecting Pipeline Stage

This block is one register stage in a pipeline that carries an N-bit word in two-rail, return-to-zero code. Every bit has a TRUE rail and a FALSE rail. Both rails low is the spacer value (NULL). Exactly one rail high is a data value. Both rails high is illegal. The stage does not use a request strobe or a timed delay. It works out from the code itself when the incoming word is entirely DATA, and later when the word is entirely NULL again.

The stage alternates between holding a NULL word and holding a DATA word. It takes in a DATA wave only when two conditions hold: every bit of the input is in a data code, and the downstream stage is asking for data (its acknowledge is low). It releases back to NULL only when two conditions hold: every input bit has returned to NULL, and the downstream stage has acknowledged (its acknowledge is high). The stage's own acknowledge to the upstream stage shows which of the two it currently holds, which closes a four-phase loop on each side.

Any bit that shows both rails high sets an error flag. The flag stays set until reset, and that bit never counts as complete. The design is clocked, synthesizable logic that models the handshake one clock edge at a time.

Top module: `dr_pipe_stage`

## Requirements
- R1: During and after a synchronous reset, both output rails of every bit are 0 (NULL), `up_ack` is 0 (data requested) and `err` is 0.
- R2: While the stage holds NULL, a complete DATA input with `dn_ack` low is copied to the outputs, and `up_ack` rises, at the next clock edge.
- R3: If any input bit is still NULL (both rails 0), the stage holding NULL does not capture, whatever the other bits show.
- R4: While `dn_ack` is high, the stage holding NULL does not capture, even when the input word is complete DATA.
- R5: While the stage holds DATA, an all-NULL input with `dn_ack` high sets every output bit to NULL and lowers `up_ack` at the next clock edge.
- R6: While any input bit still carries a data code, the stage holding DATA keeps its outputs and `up_ack` unchanged.
- R7: While `dn_ack` is low, the stage holding DATA does not release, even when the input is all NULL.
- R8: An input bit with both rails high sets `err` at the next clock edge, and `err` stays 1 until reset. Such a bit counts as neither DATA nor NULL, so the word cannot complete.
- R9: The bit encoding is {t,f}: TRUE is t=1,f=0 and FALSE is t=0,f=1. A captured bit appears on the outputs with the same encoding, so while `up_ack` is 1 every output bit has exactly one rail high.
- R10: Two identical DATA words sent one after the other, with a NULL wave between them, are both captured.
- R11: The outputs never show both rails high on a bit, and they change only when `up_ack` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_t | input | W | TRUE rails of the incoming word |
| din_f | input | W | FALSE rails of the incoming word |
| dn_ack | input | 1 | Acknowledge from downstream: 0 requests DATA, 1 requests NULL |
| up_ack | output | 1 | Acknowledge to upstream: 1 while holding DATA, 0 while holding NULL |
| dout_t | output | W | TRUE rails of the held word |
| dout_f | output | W | FALSE rails of the held word |
| err | output | 1 | Sticky flag for an illegal both-rails-high input bit |

## Verification
Every result of this stage (the held word, `up_ack` and `err`) passes through exactly one register. An input pattern and `dn_ack` value that are driven between two rising edges therefore show their effect right after the next rising edge. The driver applies each stimulus at a falling edge and queues the outcome it expects for that same following rising edge. The monitor pops one entry per cycle, a quarter period after each rising edge, so each comparison lines up with the stimulus that caused it. The cases where the stage must hold are checked the same way, by expecting the outputs from the previous cycle: an incomplete word, a downstream stage that is not ready, a partly returned NULL wave, and an illegal code.

// File: rtl/dr_stage_pkg.sv
package dr_stage_pkg;

  // Two-rail code of one bit, packed as {t, f}
  typedef enum logic [1:0] {
    CODE_NULL  = 2'b00,
    CODE_FALSE = 2'b01,
    CODE_TRUE  = 2'b10,
    CODE_BAD   = 2'b11
  } rail_code_t;

  // Which wave the stage currently holds
  typedef enum logic {
    HOLD_NULL = 1'b0,
    HOLD_DATA = 1'b1
  } hold_state_t;

  function automatic rail_code_t to_code(input logic t, input logic f);
    return rail_code_t'({t, f});
  endfunction

endpackage

// File: rtl/dr_completion.sv
module dr_completion
  import dr_stage_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] rail_t,
  input  logic [W-1:0] rail_f,
  output logic         all_data,
  output logic         all_null,
  output logic         any_bad
);

  logic [W-1:0] bit_data;
  logic [W-1:0] bit_null;
  logic [W-1:0] bit_bad;

  // Each bit is sorted into one of its three classes on its own
  for (genvar i = 0; i < W; i++) begin : g_bit
    rail_code_t code;
    always_comb begin
      code        = to_code(rail_t[i], rail_f[i]);
      bit_data[i] = (code == CODE_TRUE) || (code == CODE_FALSE);
      bit_null[i] = (code == CODE_NULL);
      bit_bad[i]  = (code == CODE_BAD);
    end
  end

  // A bad bit is in neither set, so it keeps the word from completing
  assign all_data = &bit_data;
  assign all_null = &bit_null;
  assign any_bad  = |bit_bad;

endmodule

// File: rtl/dr_wave_ctrl.sv
module dr_wave_ctrl
  import dr_stage_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic all_data,
  input  logic all_null,
  input  logic any_bad,
  input  logic dn_ack,
  output logic load_data,
  output logic load_null,
  output logic hold_ack,
  output logic err_flag
);

  hold_state_t state_q;

  always_comb begin
    load_data = 1'b0;
    load_null = 1'b0;
    unique case (state_q)
      HOLD_NULL: load_data = all_data && !dn_ack;
      HOLD_DATA: load_null = all_null &&  dn_ack;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= HOLD_NULL;
      err_flag <= 1'b0;
    end else begin
      if (load_data)     state_q <= HOLD_DATA;
      else if (load_null) state_q <= HOLD_NULL;
      if (any_bad)       err_flag <= 1'b1;
    end
  end

  assign hold_ack = (state_q == HOLD_DATA);

endmodule

// File: rtl/dr_word_reg.sv
module dr_word_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_data,
  input  logic         load_null,
  input  logic [W-1:0] d_t,
  input  logic [W-1:0] d_f,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f
);

  always_ff @(posedge clk) begin
    if (rst || load_null) begin
      q_t <= '0;
      q_f <= '0;
    end else if (load_data) begin
      q_t <= d_t;
      q_f <= d_f;
    end
  end

endmodule

// File: rtl/dr_pipe_stage.sv
module dr_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din_t,
  input  logic [W-1:0] din_f,
  input  logic         dn_ack,
  output logic         up_ack,
  output logic [W-1:0] dout_t,
  output logic [W-1:0] dout_f,
  output logic         err
);

  logic all_data, all_null, any_bad;
  logic load_data, load_null;

  dr_completion #(.W(W)) u_compl (
    .rail_t   (din_t),
    .rail_f   (din_f),
    .all_data (all_data),
    .all_null (all_null),
    .any_bad  (any_bad)
  );

  dr_wave_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .all_data  (all_data),
    .all_null  (all_null),
    .any_bad   (any_bad),
    .dn_ack    (dn_ack),
    .load_data (load_data),
    .load_null (load_null),
    .hold_ack  (up_ack),
    .err_flag  (err)
  );

  dr_word_reg #(.W(W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .load_data (load_data),
    .load_null (load_null),
    .d_t       (din_t),
    .d_f       (din_f),
    .q_t       (dout_t),
    .q_f       (dout_f)
  );

endmodule

// File: rtl/dr_pipe_stage_chk.sv
module dr_pipe_stage_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         dn_ack,
  input logic         up_ack,
  input logic [W-1:0] dout_t,
  input logic [W-1:0] dout_f,
  input logic         err
);

  a_r1_reset_null: assert property (@(posedge clk)
    rst |=> (dout_t == '0 && dout_f == '0 && !up_ack && !err));

  a_r2_capture_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(up_ack) |-> $past(!dn_ack));

  a_r5_release_to_null: assert property (@(posedge clk) disable iff (rst)
    $fell(up_ack) |-> ($past(dn_ack) && dout_t == '0 && dout_f == '0));

  a_r9_one_hot_held: assert property (@(posedge clk) disable iff (rst)
    up_ack |-> ((dout_t ^ dout_f) == {W{1'b1}}));

  a_r11_never_illegal: assert property (@(posedge clk) disable iff (rst)
    (dout_t & dout_f) == '0);

  a_r11_stable_between: assert property (@(posedge clk) disable iff (rst)
    $stable(up_ack) |-> ($stable(dout_t) && $stable(dout_f)));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

bind dr_pipe_stage dr_pipe_stage_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .dn_ack (dn_ack),
  .up_ack (up_ack),
  .dout_t (dout_t),
  .dout_f (dout_f),
  .err    (err)
);

// File: tb/dr_pipe_stage_tb.sv
module dr_pipe_stage_tb;

  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0] t;
    logic [W-1:0] f;
    logic         ack;
    logic         err;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din_t = '0;
  logic [W-1:0] din_f = '0;
  logic         dn_ack = 1'b0;
  logic         up_ack;
  logic [W-1:0] dout_t;
  logic [W-1:0] dout_f;
  logic         err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dr_pipe_stage #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .din_t(din_t), .din_f(din_f), .dn_ack(dn_ack),
    .up_ack(up_ack), .dout_t(dout_t), .dout_f(dout_f), .err(err)
  );

  // Driver: apply at falling edge, queue the outcome due after the next rising edge
  task automatic step(input logic r, input logic [W-1:0] it, input logic [W-1:0] ifl,
                      input logic da, input logic [W-1:0] et, input logic [W-1:0] ef,
                      input logic ea, input logic ee, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; din_t = it; din_f = ifl; dn_ack = da;
    e.t = et; e.f = ef; e.ack = ea; e.err = ee; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: one comparison a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (dout_t !== e.t || dout_f !== e.f || up_ack !== e.ack || err !== e.err) begin
        errors++;
        $display("FAIL %s: got t=%h f=%h ack=%b err=%b, expected t=%h f=%h ack=%b err=%b",
                 e.tag, dout_t, dout_f, up_ack, err, e.t, e.f, e.ack, e.err);
      end
    end
  end

  initial begin
    // R1 reset state
    step(1, 8'h00, 8'h00, 0, 8'h00, 8'h00, 0, 0, "R1 reset");
    step(1, 8'hA5, 8'h5A, 0, 8'h00, 8'h00, 0, 0, "R1 reset ignores input");
    // R2 capture of a mixed word, R9 encoding kept
    step(0, 8'hA5, 8'h5A, 0, 8'hA5, 8'h5A, 1, 0, "R2 capture");
    step(0, 8'hA5, 8'h5A, 0, 8'hA5, 8'h5A, 1, 0, "R11 hold");
    step(0, 8'hA5, 8'h5A, 1, 8'hA5, 8'h5A, 1, 0, "R6 input still data");
    // R6 partial NULL: upper four bits returned
    step(0, 8'h05, 8'h0A, 1, 8'hA5, 8'h5A, 1, 0, "R6 partial null");
    // R7 complete NULL but downstream still requests data
    step(0, 8'h00, 8'h00, 0, 8'hA5, 8'h5A, 1, 0, "R7 no release");
    // R5 release
    step(0, 8'h00, 8'h00, 1, 8'h00, 8'h00, 0, 0, "R5 release");
    // R3 incomplete: bits 7..4 still NULL
    step(0, 8'h0F, 8'h00, 0, 8'h00, 8'h00, 0, 0, "R3 incomplete");
    // R4 complete but downstream not ready
    step(0, 8'hFF, 8'h00, 1, 8'h00, 8'h00, 0, 0, "R4 downstream busy");
    step(0, 8'hFF, 8'h00, 0, 8'hFF, 8'h00, 1, 0, "R9 all TRUE");
    step(0, 8'h00, 8'h00, 1, 8'h00, 8'h00, 0, 0, "R5 release");
    // R10 same word again after NULL
    step(0, 8'hFF, 8'h00, 0, 8'hFF, 8'h00, 1, 0, "R10 repeat word");
    step(0, 8'h00, 8'h00, 1, 8'h00, 8'h00, 0, 0, "R5 release");
    step(0, 8'h00, 8'hFF, 0, 8'h00, 8'hFF, 1, 0, "R9 all FALSE");
    step(0, 8'h00, 8'h00, 1, 8'h00, 8'h00, 0, 0, "R5 release");
    // R8 illegal code on bit 0
    step(0, 8'hFF, 8'h01, 0, 8'h00, 8'h00, 0, 1, "R8 illegal blocks capture");
    step(0, 8'hFE, 8'h01, 0, 8'hFE, 8'h01, 1, 1, "R8 sticky after capture");
    step(0, 8'h00, 8'h00, 1, 8'h00, 8'h00, 0, 1, "R8 sticky after release");
    step(1, 8'h00, 8'h00, 0, 8'h00, 8'h00, 0, 0, "R1 reset clears err");
    step(0, 8'h3C, 8'hC3, 0, 8'h3C, 8'hC3, 1, 0, "R2 capture after reset");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule